// File: doc/BRIEF.md
# Tick-driven compare timer with interrupt status and watchdog

The block keeps a 32-bit up-counter that advances by one on every clock cycle in which the tick-enable input is high. The tick enable is produced outside the block from a fixed reference clock. Four compare registers watch the counter. When a tick moves the counter onto a compare value, the channel records an event in a sticky status register, provided its interrupt enable bit is set. The status bit drives that channel's interrupt line. Software clears a status bit by writing a one to it.

The last compare channel can also act as a watchdog. Once software arms it, a match on that channel raises a reset-request output. The request stays high until the block's own reset, and software cannot disarm the watchdog. Software reaches every register through a simple word-aligned register port with single-cycle write and read strobes. Any access to an offset that is not in the map returns zero, changes nothing and pulses an error flag.

Top module: `ostm_timer`

## Requirements
- R1: The counter resets to 0. It increments by exactly 1, wrapping from 0xFFFFFFFF to 0, on each cycle with `tick_en` high, and holds its value otherwise. Software reads it at offset 0x10.
- R2: A write to offset 0x10 loads the counter at the next edge. The load takes priority over a tick in the same cycle, and the load itself never produces a match. The next tick then advances from the loaded value.
- R3: Channel n matches when a tick moves the counter to a value equal to compare register n. A counter that holds or stays equal to the compare value produces no further event.
- R4: A match on channel n sets status bit n, and with it `irq[n]`, at the edge of the tick, but only if interrupt-enable bit n is set at that time. A match that occurs while the bit is clear is dropped, and enabling the bit later does not recover it.
- R5: The status register at offset 0x14 holds one bit per channel in bits 3..0. Writing 1 to a bit clears it. Bits written as 0 are unchanged. A match in the same cycle as a clear of the same bit leaves the bit set.
- R6: The interrupt-enable register at offset 0x1C keeps bits 11..0 and reads 0 in bits 31..12. Bits 3..0 gate channels 3..0.
- R7: Compare register n sits at offset 4*n (0x00, 0x04, 0x08, 0x0C). It resets to 0 and reads back the last value written.
- R8: The watchdog register at offset 0x18 reads the arm flag in bit 0 and the request flag in bit 1. Writing 1 to bit 0 arms the watchdog. A channel-3 match while armed raises `wdt_reset_req` at the tick's edge, whatever interrupt-enable bit 3 is.
- R9: The arm flag and `wdt_reset_req` both stay set until `rst_n` is asserted. Writing 0 to the watchdog register, and any other register write, leaves them set.
- R10: A read or write at an offset outside the map, including any offset not aligned to 4, changes no state and returns 0 on a read. It also drives `reg_err` high for exactly the one cycle after the access.
- R11: `reg_rdata` takes the addressed register's value at the edge that ends a cycle with `reg_rd` high, and holds between reads. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe from the reference clock domain logic |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| reg_err | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq | output | 4 | Per-channel interrupt lines, equal to the status bits |
| wdt_reset_req | output | 1 | Sticky watchdog reset request |

## Verification
On every cycle, the assertions check the following: the counter steps by one or holds, according to tick and load; a new interrupt appears only on a tick and only for a channel whose enable was set; a cleared status bit stays low when no tick occurs; the error flag follows an unmapped access; and the watchdog request is sticky and rises only when armed. The bench scenarios show what the assertions cannot. These are the exact tick on which each match fires, and that a disabled match is not recovered later. They also show that a clear and a match in the same cycle leave the bit set, that a counter load never matches, and that the watchdog survives a write of zero. Register values read back after an unmapped write must be unchanged.

// File: rtl/ostm_pkg.sv
package ostm_pkg;

    // Register offsets whose position software depends on
    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_WDOG   = 8'h18;
    localparam logic [7:0] OFS_IEN    = 8'h1C;

    // Register selected by the decoder
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_WDOG,
        SEL_IEN
    } reg_sel_e;

endpackage

// File: rtl/ostm_decode.sv
module ostm_decode
    import ostm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [CH_W-1:0]   ch
);

    logic [ADDR_W-1:0] word_idx;

    assign word_idx = addr >> 2;

    always_comb begin
        sel = SEL_NONE;
        ch  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(OFS_COUNT)) begin
                sel = SEL_COUNT;
            end else if (addr == ADDR_W'(OFS_STATUS)) begin
                sel = SEL_STATUS;
            end else if (addr == ADDR_W'(OFS_WDOG)) begin
                sel = SEL_WDOG;
            end else if (addr == ADDR_W'(OFS_IEN)) begin
                sel = SEL_IEN;
            end else if (addr < ADDR_W'(4 * NUM_CH)) begin
                sel = SEL_MATCH;
                ch  = CH_W'(word_idx);
            end
        end
    end

endmodule

// File: rtl/ostm_match_bank.sv
module ostm_match_bank #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic                           advance,
    input  logic [DATA_W-1:0]              next_count,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  match_val,
    output logic [NUM_CH-1:0]              hit
);

    // One equality comparator per channel, qualified by the tick advance
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        assign hit[g] = advance && (next_count == match_val[g]);
    end

endmodule

// File: rtl/ostm_rdmux.sv
module ostm_rdmux
    import ostm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int IEN_W  = 12,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  reg_sel_e                       sel,
    input  logic [CH_W-1:0]                ch,
    input  logic [DATA_W-1:0]              count,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  match_val,
    input  logic [NUM_CH-1:0]              status,
    input  logic [IEN_W-1:0]               ien,
    input  logic                           wdog_arm,
    input  logic                           wdog_req,
    output logic [DATA_W-1:0]              rdata
);

    always_comb begin
        unique case (sel)
            SEL_MATCH:  rdata = match_val[ch];
            SEL_COUNT:  rdata = count;
            SEL_STATUS: rdata = DATA_W'(status);
            SEL_WDOG:   rdata = DATA_W'({wdog_req, wdog_arm});
            SEL_IEN:    rdata = DATA_W'(ien);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ostm_timer.sv
module ostm_timer
    import ostm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int IEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_err,
    output logic [NUM_CH-1:0] irq,
    output logic              wdt_reset_req
);

    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WDG_CH = NUM_CH - 1;

    typedef struct packed {
        logic [DATA_W-1:0]             count;
        logic [NUM_CH-1:0][DATA_W-1:0] match_val;
        logic [NUM_CH-1:0]             status;
        logic [IEN_W-1:0]              ien;
        logic                          wdog_arm;
        logic                          wdog_req;
        logic [DATA_W-1:0]             rdata;
        logic                          err;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e          sel;
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] count_inc;
    logic              load_cnt;
    logic              advance;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] clr_mask;

    ostm_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_decode (
        .addr (reg_addr),
        .sel  (sel),
        .ch   (ch)
    );

    assign count_inc = st_q.count + DATA_W'(1);
    assign load_cnt  = reg_wr && (sel == SEL_COUNT);
    assign advance   = tick_en && !load_cnt;

    ostm_match_bank #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_match (
        .advance    (advance),
        .next_count (count_inc),
        .match_val  (st_q.match_val),
        .hit        (hit)
    );

    ostm_rdmux #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .IEN_W  (IEN_W)
    ) u_rdmux (
        .sel       (sel),
        .ch        (ch),
        .count     (st_q.count),
        .match_val (st_q.match_val),
        .status    (st_q.status),
        .ien       (st_q.ien),
        .wdog_arm  (st_q.wdog_arm),
        .wdog_req  (st_q.wdog_req),
        .rdata     (rd_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        clr_mask = '0;

        // Counter: a software load wins over the tick
        if (load_cnt) begin
            st_d.count = reg_wdata;
        end else if (tick_en) begin
            st_d.count = count_inc;
        end

        if (reg_wr && (sel == SEL_MATCH)) begin
            st_d.match_val[ch] = reg_wdata;
        end

        if (reg_wr && (sel == SEL_IEN)) begin
            st_d.ien = reg_wdata[IEN_W-1:0];
        end

        if (reg_wr && (sel == SEL_STATUS)) begin
            clr_mask = reg_wdata[NUM_CH-1:0];
        end

        // Clear first, then a gated match sets (set has priority)
        st_d.status = (st_q.status & ~clr_mask) | (hit & st_q.ien[NUM_CH-1:0]);

        // Watchdog arm is set-only; request is sticky until reset
        if (reg_wr && (sel == SEL_WDOG) && reg_wdata[0]) begin
            st_d.wdog_arm = 1'b1;
        end
        if (hit[WDG_CH] && st_q.wdog_arm) begin
            st_d.wdog_req = 1'b1;
        end

        if (reg_rd) begin
            st_d.rdata = rd_val;
        end

        st_d.err = (reg_rd || reg_wr) && (sel == SEL_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata     = st_q.rdata;
    assign reg_err       = st_q.err;
    assign irq           = st_q.status;
    assign wdt_reset_req = st_q.wdog_req;

endmodule

// File: rtl/ostm_timer_chk.sv
module ostm_timer_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NUM_CH-1:0] wdata_low,
    input logic              reg_err,
    input logic [NUM_CH-1:0] irq,
    input logic              wdt_reset_req,
    input logic [DATA_W-1:0] count_q,
    input logic [NUM_CH-1:0] ien_low,
    input logic              wdog_arm_q
);

    logic addr_mapped;
    logic cnt_write;
    logic stat_write;

    assign addr_mapped = (reg_addr[1:0] == 2'b00) &&
                         ((reg_addr < ADDR_W'(4 * NUM_CH)) ||
                          (reg_addr == ADDR_W'(8'h10)) || (reg_addr == ADDR_W'(8'h14)) ||
                          (reg_addr == ADDR_W'(8'h18)) || (reg_addr == ADDR_W'(8'h1C)));
    assign cnt_write   = reg_wr && (reg_addr == ADDR_W'(8'h10));
    assign stat_write  = reg_wr && (reg_addr == ADDR_W'(8'h14));

    a_r1_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick_en && !cnt_write) |-> (count_q == $past(count_q) + DATA_W'(1)));

    a_r1_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tick_en && !cnt_write) |-> $stable(count_q));

    a_r3_irq_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> $past(tick_en));

    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq) & ~$past(ien_low)) == '0));

    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_write && !tick_en) |-> ((irq & $past(wdata_low)) == '0));

    a_r8_wdt_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_reset_req) |-> $past(wdog_arm_q));

    a_r9_wdt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wdt_reset_req) |-> wdt_reset_req);

    a_r9_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wdog_arm_q) |-> wdog_arm_q);

    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past((reg_rd || reg_wr) && !addr_mapped));

    a_r10_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past((reg_rd || reg_wr) && !addr_mapped) |-> reg_err);

endmodule

bind ostm_timer ostm_timer_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .wdata_low     (reg_wdata[NUM_CH-1:0]),
    .reg_err       (reg_err),
    .irq           (irq),
    .wdt_reset_req (wdt_reset_req),
    .count_q       (st_q.count),
    .ien_low       (st_q.ien[NUM_CH-1:0]),
    .wdog_arm_q    (st_q.wdog_arm)
);

// File: tb/ostm_timer_test.sv
module ostm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic [3:0]  irq;
    logic        wdt_reset_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] m_cnt;
    logic [31:0] m_match [4];
    logic [3:0]  m_stat;
    logic [11:0] m_ien;
    logic        m_arm, m_req, m_err;
    logic [31:0] m_rdata;

    always #10 clk = ~clk;

    ostm_timer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .reg_err       (reg_err),
        .irq           (irq),
        .wdt_reset_req (wdt_reset_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_valid(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a < 8'h10 || a == 8'h10 || a == 8'h14 || a == 8'h18 || a == 8'h1C);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (!m_valid(a)) return 32'h0;
        if (a < 8'h10)   return m_match[a[3:2]];
        if (a == 8'h10)  return m_cnt;
        if (a == 8'h14)  return {28'h0, m_stat};
        if (a == 8'h18)  return {30'h0, m_req, m_arm};
        return {20'h0, m_ien};
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_stat = '0; m_ien = '0; m_arm = 0; m_req = 0; m_err = 0; m_rdata = '0;
        for (int i = 0; i < 4; i++) m_match[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One clock cycle of stimulus; model update and full output comparison
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] d, input logic tk);
        logic        load, wvalid;
        logic [3:0]  hits, clr;
        logic [31:0] inc;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; tick_en = tk;
        @(posedge clk);
        wvalid = wr && m_valid(a);
        load = wvalid && (a == 8'h10);
        inc  = m_cnt + 32'd1;
        for (int i = 0; i < 4; i++) hits[i] = tk && !load && (inc == m_match[i]);
        clr = (wvalid && a == 8'h14) ? d[3:0] : 4'h0;
        if (rd) m_rdata = m_read(a);
        m_err = (rd || wr) && !m_valid(a);
        if (hits[3] && m_arm) m_req = 1'b1;
        m_stat = (m_stat & ~clr) | (hits & m_ien[3:0]);
        if (load) m_cnt = d; else if (tk) m_cnt = inc;
        if (wvalid && a < 8'h10) m_match[a[3:2]] = d;
        if (wvalid && a == 8'h1C) m_ien = d[11:0];
        if (wvalid && a == 8'h18 && d[0]) m_arm = 1'b1;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; tick_en = 0;
        chk(irq == m_stat, "R4 irq", {28'h0, irq}, {28'h0, m_stat});
        chk(wdt_reset_req == m_req, "R8 wdt", {31'h0, wdt_reset_req}, {31'h0, m_req});
        chk(reg_err == m_err, "R10 err", {31'h0, reg_err}, {31'h0, m_err});
        chk(reg_rdata == m_rdata, "R11 rdata", reg_rdata, m_rdata);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h0, 32'h0, 1'b1);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string req);
        step(1'b0, 1'b1, a, 32'h0, 1'b0);
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        model_reset();
        do_reset();

        // Reset state (R1, R7, R11)
        chk(irq == 4'h0 && !wdt_reset_req && !reg_err, "R1 reset outputs", {27'h0, irq, wdt_reset_req}, 32'h0);
        chk(reg_rdata == 32'h0, "R11 reset rdata", reg_rdata, 32'h0);
        rd_exp(8'h10, 32'h0, "R1 count after reset");
        rd_exp(8'h08, 32'h0, "R7 match reset value");

        // Constrained random phase
        for (int it = 0; it < 3000; it++) begin
            int op;
            logic tk;
            op = int'($urandom % 16);
            tk = 1'($urandom);
            case (op)
                0, 1, 2, 3, 4: step(0, 0, 8'h0, 32'h0, 1'b1);
                5, 6:  step(1, 0, 8'(($urandom % 4) * 4), m_cnt + 32'd1 + ($urandom % 6), tk);
                7:     step(1, 0, 8'h14, $urandom, tk);
                8:     step(1, 0, 8'h1C, $urandom, tk);
                9, 10: step(0, 1, 8'(($urandom % 8) * 4), 32'h0, tk);
                11:    step(1, 0, 8'h10, ($urandom % 2) ? $urandom : m_cnt - 32'd3, tk);
                12:    step(1'($urandom), 1'b0, 8'($urandom), $urandom, tk);
                13:    step(0, 1, 8'($urandom), 32'h0, tk);
                default: step(0, 1, 8'h10, 32'h0, 1'b1);
            endcase
        end

        // Directed corner cases
        do_reset();
        ticks(5);
        rd_exp(8'h10, 32'd5, "R1 count after five ticks");

        wr(8'h04, 32'hDEADBEEF);
        rd_exp(8'h04, 32'hDEADBEEF, "R7 match readback");

        wr(8'h1C, 32'hFFFFFFFF);
        rd_exp(8'h1C, 32'h00000FFF, "R6 enable width");
        wr(8'h1C, 32'h0);

        step(1, 0, 8'h10, 32'h100, 1'b1);
        rd_exp(8'h10, 32'h100, "R2 load beats tick");

        wr(8'h00, 32'h103);
        wr(8'h1C, 32'h1);
        ticks(2);
        chk(irq[0] == 1'b0, "R3 no early match", {31'h0, irq[0]}, 32'h0);
        ticks(1);
        chk(irq[0] == 1'b1, "R3 match on tick", {31'h0, irq[0]}, 32'h1);
        ticks(2);
        chk(irq[0] == 1'b1, "R5 status sticky", {31'h0, irq[0]}, 32'h1);
        wr(8'h14, 32'h0);
        chk(irq[0] == 1'b1, "R5 zero write keeps bit", {31'h0, irq[0]}, 32'h1);
        wr(8'h14, 32'h1);
        chk(irq[0] == 1'b0, "R5 one write clears", {31'h0, irq[0]}, 32'h0);
        ticks(3);
        chk(irq[0] == 1'b0, "R3 fires once", {31'h0, irq[0]}, 32'h0);

        // count now 0x108; disabled channel 1 match at 0x10A
        wr(8'h04, 32'h10A);
        ticks(2);
        chk(irq[1] == 1'b0, "R4 disabled match dropped", {31'h0, irq[1]}, 32'h0);
        wr(8'h1C, 32'h3);
        rd_exp(8'h14, 32'h0, "R4 late enable recovers nothing");

        // set wins over clear in the same cycle
        wr(8'h00, 32'h10C);
        ticks(1);
        step(1, 0, 8'h14, 32'h1, 1'b1);
        chk(irq[0] == 1'b1, "R5 set wins over clear", {31'h0, irq[0]}, 32'h1);
        wr(8'h14, 32'hF);

        // load onto a compare value does not match
        wr(8'h00, 32'h300);
        step(1, 0, 8'h10, 32'h300, 1'b1);
        chk(irq[0] == 1'b0, "R2 load never matches", {31'h0, irq[0]}, 32'h0);

        // wrap
        wr(8'h10, 32'hFFFFFFFF);
        ticks(1);
        rd_exp(8'h10, 32'h0, "R1 wrap to zero");

        // unmapped accesses
        rd_exp(8'h24, 32'h0, "R10 unmapped read zero");
        chk(reg_err == 1'b1, "R10 err on read", {31'h0, reg_err}, 32'h1);
        step(0, 1, 8'h11, 32'h0, 1'b0);
        chk(reg_err == 1'b1, "R10 err on misaligned", {31'h0, reg_err}, 32'h1);
        wr(8'h20, 32'hFFFFFFFF);
        chk(reg_err == 1'b1, "R10 err on write", {31'h0, reg_err}, 32'h1);
        ticks(1);
        chk(reg_err == 1'b0, "R10 err single cycle", {31'h0, reg_err}, 32'h0);
        rd_exp(8'h1C, 32'h3, "R10 write ignored");

        // watchdog: not armed, then armed with channel 3 interrupt disabled
        wr(8'h1C, 32'h0);
        wr(8'h0C, 32'h10);
        wr(8'h10, 32'h0E);
        ticks(2);
        chk(wdt_reset_req == 1'b0, "R8 unarmed no request", {31'h0, wdt_reset_req}, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h10, 32'h0E);
        ticks(1);
        chk(wdt_reset_req == 1'b0, "R8 no early request", {31'h0, wdt_reset_req}, 32'h0);
        ticks(1);
        chk(wdt_reset_req == 1'b1, "R8 armed match requests", {31'h0, wdt_reset_req}, 32'h1);
        chk(irq[3] == 1'b0, "R8 irq stays gated", {31'h0, irq[3]}, 32'h0);
        wr(8'h18, 32'h0);
        rd_exp(8'h18, 32'h3, "R9 arm and request survive zero write");
        wr(8'h14, 32'hFF);
        wr(8'h10, 32'h0);
        ticks(3);
        chk(wdt_reset_req == 1'b1, "R9 request sticky", {31'h0, wdt_reset_req}, 32'h1);
        do_reset();
        @(negedge clk);
        chk(wdt_reset_req == 1'b0, "R9 reset clears request", {31'h0, wdt_reset_req}, 32'h0);
        rd_exp(8'h18, 32'h0, "R9 reset clears arm");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule